// File: doc/BRIEF.md
# Multiplexed-Write Register File

This block gives a base-rate datapath several write ports and several read ports into one register array that has only a single write path. It runs on a fast clock whose rate is `NWR + 1` times the base rate. It splits every base cycle into `NWR + 1` subcycles:

- Subcycle 0 performs all reads.
- Subcycle `k` (for `k` from 1 to `NWR`) performs the write of port `k-1`.

A phase counter on the fast clock steers the write address and data mux. No logic uses the clock itself as a data signal.

Base-rate logic shares the fast clock. It uses the `base_tick` strobe as its clock enable:

- It presents a request set while `base_tick` is high.
- It holds that set steady until the block captures it at the edge that closes the base cycle.
- It collects the read results one base cycle later.

Because the reads of a request set happen before its writes, a base cycle behaves as write-after-read.

Top module: `mux_port_regfile`

## Requirements
- R1: While `rst_n` is low, and after its release, every register entry reads as zero, `rd_data` is zero, and `base_tick` is high in the first fast cycle after release.
- R2: `base_tick` is high for exactly one fast cycle out of every `NWR + 1`.
- R3: The request inputs (`wr_en`, `wr_addr`, `wr_data`, `rd_addr`) are sampled only at the fast edge that ends a base cycle, which is the edge after which `base_tick` rises. Values held on them at other times have no effect.
- R4: Results for a request set captured at the end of base cycle n appear on `rd_data` at the edge that ends subcycle 0 of cycle n+1. They stay constant until the same point of the next base cycle.
- R5: Reads return the array contents from before any write of the same request set.
- R6: Each write port with its `wr_en` bit set stores its data at its address. A port whose enable bit is clear changes nothing.
- R7: When several enabled write ports of one request set name the same address, the port with the highest index determines the stored value.
- R8: The `NRD` read ports are independent and may all name the same address.
- R9: Writes from one request set are visible to the reads of every later request set.
- Port `j` occupies bits `[j*AW +: AW]` of an address bus and bits `[j*W +: W]` of a data bus. `wr_en[k]` enables write port `k`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, `NWR + 1` times the base rate |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | output | 1 | High in subcycle 0 of each base cycle |
| wr_en | input | NWR | Write enable for each write port |
| wr_addr | input | NWR*AW | Write addresses, packed by port |
| wr_data | input | NWR*W | Write data, packed by port |
| rd_addr | input | NRD*AW | Read addresses, packed by port |
| rd_data | output | NRD*W | Read results, packed by port |

## Verification
A phase counter that drifts would show up at once as a wrong spacing of `base_tick`. It would also make a write land in the read subcycle. A read two base cycles later would then return a value that the reference model, which applies reads first and writes in port order, does not predict.

A mis-steered write mux would store data from the wrong port or at the wrong address. It would appear on the first read of that entry, one base cycle after it is requested. Input registers that leak mid-cycle values would be exposed by a request that is glitched between captures and later read back.

// File: rtl/mux_port_regfile.sv
module mux_port_regfile #(
  parameter int NWR   = 2,
  parameter int NRD   = 2,
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              base_tick,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*W-1:0]  wr_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*W-1:0]  rd_data
);
  localparam int NPH = NWR + 1;
  localparam int PW  = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [PW-1:0] LAST = PW'(NWR);

  logic [PW-1:0]     ph;
  logic [W-1:0]      mem [DEPTH];
  logic [NWR-1:0]    q_en;
  logic [NWR*AW-1:0] q_wa;
  logic [NWR*W-1:0]  q_wd;
  logic [NRD*AW-1:0] q_ra;
  logic [W-1:0]      rd_q [NRD];
  logic              sel_en;
  logic [AW-1:0]     sel_a;
  logic [W-1:0]      sel_d;

  wire boundary = (ph == LAST);
  assign base_tick = (ph == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= '0;
    else        ph <= boundary ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_en <= '0;
      q_wa <= '0;
      q_wd <= '0;
      q_ra <= '0;
    end else if (boundary) begin
      q_en <= wr_en;
      q_wa <= wr_addr;
      q_wd <= wr_data;
      q_ra <= rd_addr;
    end
  end

  always_comb begin
    sel_en = 1'b0;
    sel_a  = '0;
    sel_d  = '0;
    for (int k = 0; k < NWR; k++) begin
      if (ph == PW'(k + 1)) begin
        sel_en = q_en[k];
        sel_a  = q_wa[k*AW +: AW];
        sel_d  = q_wd[k*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (sel_en) begin
      mem[sel_a] <= sel_d;
    end
  end

  for (genvar j = 0; j < NRD; j++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)         rd_q[j] <= '0;
      else if (base_tick) rd_q[j] <= mem[q_ra[j*AW +: AW]];
    end
    assign rd_data[j*W +: W] = rd_q[j];
  end
endmodule

// File: rtl/mux_port_regfile_chk.sv
module mux_port_regfile_chk #(
  parameter int NWR = 2,
  parameter int NRD = 2,
  parameter int W   = 8,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base_tick,
  input logic [NRD*W-1:0]  rd_data,
  input logic [NWR-1:0]    q_en,
  input logic [NWR*AW-1:0] q_wa,
  input logic [NWR*W-1:0]  q_wd,
  input logic [NRD*AW-1:0] q_ra
);
  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (base_tick) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && seen) |-> (gap == NWR));
  a_r2_tick_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |-> (gap < NWR));
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |-> ($stable(q_en) && $stable(q_wa) && $stable(q_wd) && $stable(q_ra)));
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> $stable(rd_data));
endmodule

bind mux_port_regfile mux_port_regfile_chk #(.NWR(NWR), .NRD(NRD), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rd_data(rd_data),
  .q_en(q_en), .q_wa(q_wa), .q_wd(q_wd), .q_ra(q_ra)
);

// File: tb/mux_port_regfile_test.sv
`timescale 1ns/1ps
module mux_port_regfile_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        base_tick;
  logic [1:0]  wr_en = '0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int nchk = 0, nfail = 0, ticks = 0, gap = 0;
  bit done = 0;
  logic [7:0]  mdl [16];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  mux_port_regfile uut (.clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    gap++;
    if (base_tick) begin
      if (ticks > 0) chk(gap == 3, "R2 tick spacing", gap, 3);
      gap = 0;
      if (ticks < 2) chk(rd_data == 16'h0, "R1 reset rd_data", int'(rd_data), 0);
      else if (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data[7:0] == e[7:0], {t, " port0"}, int'(rd_data[7:0]), int'(e[7:0]));
        chk(rd_data[15:8] == e[15:8], {t, " port1"}, int'(rd_data[15:8]), int'(e[15:8]));
      end
      ticks++;
    end
  end

  task automatic issue(input logic [1:0] en, input logic [3:0] a0, input logic [7:0] d0,
                       input logic [3:0] a1, input logic [7:0] d1,
                       input logic [3:0] r0, input logic [3:0] r1,
                       input string tag, input bit glitch = 0);
    forever begin
      @(negedge clk);
      if (base_tick) break;
    end
    wr_en = en;
    wr_addr = {a1, a0};
    wr_data = {d1, d0};
    rd_addr = {r1, r0};
    exp_q.push_back({mdl[r1], mdl[r0]});
    tag_q.push_back(tag);
    if (en[0]) mdl[a0] = d0;
    if (en[1]) mdl[a1] = d1;
    if (glitch) begin
      @(negedge clk);
      wr_en = 2'b11;
      wr_addr = {4'd5, 4'd5};
      wr_data = 16'hAAAA;
      rd_addr = 8'hFF;
      @(negedge clk);
      wr_en = en;
      wr_addr = {a1, a0};
      wr_data = {d1, d0};
      rd_addr = {r1, r0};
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    chk(rd_data == 16'h0, "R1 rd_data in reset", int'(rd_data), 0);
    #1 rst_n = 1;
    issue(2'b00, 0, 0, 0, 0, 0, 0, "R1 idle");
    issue(2'b00, 0, 0, 0, 0, 0, 0, "R1 idle");
    issue(2'b11, 3, 8'h11, 7, 8'h22, 3, 7, "R5 R1 read before write");
    issue(2'b00, 0, 0, 0, 0, 3, 7, "R6 R9 written values");
    issue(2'b10, 9, 8'h5A, 3, 8'h33, 3, 3, "R5 R8 same address");
    issue(2'b00, 0, 0, 0, 0, 9, 3, "R6 disabled port and enabled port");
    issue(2'b11, 4, 8'h44, 4, 8'h55, 4, 4, "R5 collision prior");
    issue(2'b00, 0, 0, 0, 0, 4, 4, "R7 higher port wins");
    issue(2'b01, 6, 8'h66, 0, 0, 6, 5, "R3 glitched set", 1);
    issue(2'b00, 0, 0, 0, 0, 5, 6, "R3 glitch ignored");
    for (int i = 0; i < 16; i++)
      issue(2'(i % 4), 4'(i), 8'(i * 7 + 1), 4'(15 - i), 8'(i * 13 + 2),
            4'(i * 5), 4'(i + 3), "R9 R4 pattern");
    for (int i = 0; i < 16; i += 2)
      issue(2'b00, 0, 0, 0, 0, 4'(i), 4'(i + 1), "R6 R9 final sweep");
    issue(2'b00, 0, 0, 0, 0, 0, 0, "R4 drain");
    issue(2'b00, 0, 0, 0, 0, 0, 0, "R4 drain");
    issue(2'b00, 0, 0, 0, 0, 0, 0, "R4 drain");
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule